// File: doc/BRIEF.md
# Post-Increment Address Wrap Detector

This block holds the base address used for external memory accesses and steps it forward by one after each completed access. It is built for buffers whose size depends on the current transfer mode. A 4-bit mode code, a 3-bit word-length code and a bus-width bit together choose how many low address bits form the word address. The increment acts on that low field only, and a wrap is the moment that field goes from all ones to all zeros.

A wrap can raise a sticky interrupt request, but only while the interrupt enable is set. The core clears the request by pulsing an acknowledge input. The core can also load a new base address at any time, and a load overrides an increment in the same cycle. A software reset clears the interrupt enable and any pending request, and leaves the address where it is.

Top module: `addr_wrap_incr`

## Requirements
- R1: While `rst_n` is low, `addr` becomes 0, `wrap_ie` becomes 0 and `wrap_irq` becomes 0.
- R2: On a rising clock edge where `access_done` is 1, at least one of `rd_inc_en` or `wr_inc_en` is 1, and `load_we` is 0, the significant low field of `addr` goes up by one.
- R3: When `rd_inc_en` and `wr_inc_en` are both 0, a pulse on `access_done` leaves `addr` unchanged and cannot set `wrap_irq`.
- R4: When `mode_sel` is 4'b1101, bits [17:0] form the significant field. An increment from all ones in [17:0] gives zero in [17:0] and counts as a wrap.
- R5: When `mode_sel` is 4'b0101, `word_len` is 3'b001 and `bus_wide` is 0, bits [15:0] form the significant field and wrap as in R4.
- R6: For every other combination of `mode_sel`, `word_len` and `bus_wide`, all `ADDR_W` bits form the field. The wrap is the step from all ones to zero.
- R7: An increment never changes any address bit above the significant field.
- R8: A wrap sets `wrap_irq` on the same edge that updates `addr`, but only if `wrap_ie` is 1 before that edge. Once set, `wrap_irq` stays 1 until it is cleared.
- R9: `irq_ack` high clears `wrap_irq` at the next edge. If a new wrap happens in that same cycle, the set wins and `wrap_irq` stays 1.
- R10: `load_we` high writes `load_data` into `addr` at the next edge. If this coincides with an increment, the load wins and no wrap is recorded.
- R11: `sw_rst` high clears `wrap_ie` and `wrap_irq` at the next edge and leaves `addr` unchanged.
- R12: `wrap_ie_we` high writes `wrap_ie_d` into `wrap_ie` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_rst | input | 1 | Software reset: clears the interrupt enable and the pending request |
| mode_sel | input | 4 | Addressing mode code |
| word_len | input | 3 | Word-length code |
| bus_wide | input | 1 | Bus-width select |
| rd_inc_en | input | 1 | Post-increment enable for reads |
| wr_inc_en | input | 1 | Post-increment enable for writes |
| access_done | input | 1 | One-cycle strobe at the end of each memory access |
| wrap_ie_we | input | 1 | Write strobe for the interrupt enable |
| wrap_ie_d | input | 1 | New interrupt enable value |
| load_we | input | 1 | Address load strobe |
| load_data | input | ADDR_W (24) | Address to load |
| irq_ack | input | 1 | Write-one-to-clear for the wrap request |
| addr | output | ADDR_W (24) | Current base address |
| wrap_ie | output | 1 | Current interrupt enable |
| wrap_irq | output | 1 | Sticky wrap interrupt request |

## Verification
The bench uses the default `ADDR_W` of 24. At that width both the 18-bit and the 16-bit fields are narrower than the register, so the bench can see whether the bits above the field survive a rollover. The full-width default then wraps only at the top of the register, which separates a correct mode decode from one that falls through to the wrong width. Starting values just below each rollover let every wrap be reached within a few cycles.

// File: rtl/addr_wrap_pkg.sv
// Package: shared codes for the post-increment address wrap detector.
// Assumes that only the two listed mode combinations narrow the field.
package addr_wrap_pkg;
    // Mode code that selects an 18-bit significant field.
    localparam logic [3:0] MODE_FIELD18   = 4'b1101;
    // Mode code that, with the word length below and a narrow bus, selects 16 bits.
    localparam logic [3:0] MODE_FIELD16   = 4'b0101;
    localparam logic [2:0] WLEN_FIELD16   = 3'b001;
    // Field widths that the narrowed modes select.
    localparam int unsigned FIELD18_BITS  = 18;
    localparam int unsigned FIELD16_BITS  = 16;
endpackage

// File: rtl/wrap_field_decode.sv
// Module: turns the mode, word-length and bus-width inputs into a mask of
// significant low address bits. Purely combinational. Assumes the field always
// starts at bit 0. Combinations not listed use the whole register.
module wrap_field_decode
    import addr_wrap_pkg::*;
#(
    parameter int unsigned ADDR_W = 24
) (
    input  logic [3:0]        mode_sel,
    input  logic [2:0]        word_len,
    input  logic              bus_wide,
    output logic [ADDR_W-1:0] field_mask
);
    localparam int unsigned SIG_W = $clog2(ADDR_W + 1);
    localparam int unsigned W18   = (ADDR_W < FIELD18_BITS) ? ADDR_W : FIELD18_BITS;
    localparam int unsigned W16   = (ADDR_W < FIELD16_BITS) ? ADDR_W : FIELD16_BITS;

    logic [SIG_W-1:0] field_bits;

    // Choose the field width from the mode inputs.
    always_comb begin
        field_bits = SIG_W'(ADDR_W);
        if (mode_sel == MODE_FIELD18) begin
            field_bits = SIG_W'(W18);
        end else if ((mode_sel == MODE_FIELD16) && (word_len == WLEN_FIELD16) && !bus_wide) begin
            field_bits = SIG_W'(W16);
        end
    end

    // Expand the width into a thermometer mask, one bit per address bit.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign field_mask[i] = (32'(field_bits) > i);
    end
endmodule

// File: rtl/wrap_field_incr.sv
// Module: adds one to the masked low field of an address and keeps the bits
// above it. Also reports whether that step would roll the field over.
// Assumes the mask is a contiguous run of ones starting at bit 0.
module wrap_field_incr #(
    parameter int unsigned ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] field_mask,
    output logic [ADDR_W-1:0] next_addr,
    output logic              field_rolls
);
    logic [ADDR_W-1:0] plus_one;

    // Add one across the whole word. The mask then keeps only the field part.
    always_comb begin
        plus_one  = cur_addr + ADDR_W'(1);
        next_addr = (cur_addr & ~field_mask) | (plus_one & field_mask);
    end

    // The field rolls over when every masked bit is already one.
    always_comb begin
        field_rolls = ((cur_addr & field_mask) == field_mask);
    end
endmodule

// File: rtl/wrap_irq_ctrl.sv
// Module: holds the wrap interrupt enable and the sticky request flag.
// Assumes wrap_evt is a single-cycle pulse that already excludes load cycles.
// A set outranks a clear in the same cycle.
module wrap_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic ie_we,
    input  logic ie_d,
    input  logic wrap_evt,
    input  logic ack,
    output logic ie_q,
    output logic irq_q
);
    // Enable register: cleared by either reset, otherwise written by the core.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            ie_q <= 1'b0;
        end else if (ie_we) begin
            ie_q <= ie_d;
        end
    end

    // Sticky request: set on an enabled wrap, cleared by acknowledge or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            irq_q <= 1'b0;
        end else if (wrap_evt && ie_q) begin
            irq_q <= 1'b1;
        end else if (ack) begin
            irq_q <= 1'b0;
        end
    end
endmodule

// File: rtl/addr_wrap_incr.sv
// Module: top of the post-increment address wrap detector. Holds the base
// address, steps its mode-selected low field after each enabled access, and
// raises a sticky interrupt when that field rolls over.
// Assumes access_done is a one-cycle strobe. A load outranks an increment.
module addr_wrap_incr #(
    parameter int unsigned ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic [3:0]        mode_sel,
    input  logic [2:0]        word_len,
    input  logic              bus_wide,
    input  logic              rd_inc_en,
    input  logic              wr_inc_en,
    input  logic              access_done,
    input  logic              wrap_ie_we,
    input  logic              wrap_ie_d,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_data,
    input  logic              irq_ack,
    output logic [ADDR_W-1:0] addr,
    output logic              wrap_ie,
    output logic              wrap_irq
);
    logic [ADDR_W-1:0] field_mask;
    logic [ADDR_W-1:0] stepped;
    logic              rolls;
    logic              step_req;
    logic              wrap_evt;

    wrap_field_decode #(.ADDR_W(ADDR_W)) u_decode (
        .mode_sel   (mode_sel),
        .word_len   (word_len),
        .bus_wide   (bus_wide),
        .field_mask (field_mask)
    );

    wrap_field_incr #(.ADDR_W(ADDR_W)) u_incr (
        .cur_addr    (addr),
        .field_mask  (field_mask),
        .next_addr   (stepped),
        .field_rolls (rolls)
    );

    // An increment is requested when an access ends with either enable set.
    always_comb begin
        step_req = access_done && (rd_inc_en || wr_inc_en);
        wrap_evt = step_req && !load_we && rolls;
    end

    // Address register: reset to zero, load first, then post-increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load_we) begin
            addr <= load_data;
        end else if (step_req) begin
            addr <= stepped;
        end
    end

    wrap_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst   (sw_rst),
        .ie_we    (wrap_ie_we),
        .ie_d     (wrap_ie_d),
        .wrap_evt (wrap_evt),
        .ack      (irq_ack),
        .ie_q     (wrap_ie),
        .irq_q    (wrap_irq)
    );
endmodule

// File: rtl/addr_wrap_sva.sv
// Checker: port-level properties of the address wrap detector, bound to the top.
module addr_wrap_sva #(
    parameter int unsigned ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst,
    input logic [3:0]        mode_sel,
    input logic              rd_inc_en,
    input logic              wr_inc_en,
    input logic              access_done,
    input logic              load_we,
    input logic [ADDR_W-1:0] load_data,
    input logic              irq_ack,
    input logic [ADDR_W-1:0] addr,
    input logic              wrap_ie,
    input logic              wrap_irq
);
    logic inc_now;
    assign inc_now = access_done && (rd_inc_en || wr_inc_en);

    // R3: without an increment or a load the address holds.
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_now && !load_we) |=> $stable(addr));

    // R3: the request cannot appear on a cycle that had no increment.
    assert_no_irq_without_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((!inc_now || load_we) && !wrap_irq) |=> !wrap_irq);

    // R10: a load always lands as given.
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (addr == $past(load_data)));

    // R8: a new request needs the enable set in the cycle before.
    assert_irq_needs_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_irq) |-> $past(wrap_ie));

    // R9: acknowledge without a competing increment clears the request.
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !sw_rst && !(inc_now && !load_we)) |=> !wrap_irq);

    // R11: software reset clears enable and request.
    assert_sw_rst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (!wrap_ie && !wrap_irq));

    // R7: in the 18-bit mode an increment keeps the bits above the field.
    if (ADDR_W > 18) begin : g_upper
        assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_sel == 4'b1101 && inc_now && !load_we)
            |=> (addr[ADDR_W-1:18] == $past(addr[ADDR_W-1:18])));
    end
endmodule

bind addr_wrap_incr addr_wrap_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_rst      (sw_rst),
    .mode_sel    (mode_sel),
    .rd_inc_en   (rd_inc_en),
    .wr_inc_en   (wr_inc_en),
    .access_done (access_done),
    .load_we     (load_we),
    .load_data   (load_data),
    .irq_ack     (irq_ack),
    .addr        (addr),
    .wrap_ie     (wrap_ie),
    .wrap_irq    (wrap_irq)
);

// File: tb/addr_wrap_incr_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each cycle from the requirements and
// queues the prediction. The monitor compares it at the falling edge.
module addr_wrap_incr_bench;
    localparam int unsigned AW = 24;

    typedef struct {
        int          due;
        logic [AW-1:0] addr;
        logic        ie;
        logic        irq;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_rst = 1'b0;
    logic [3:0]    mode_sel = '0;
    logic [2:0]    word_len = '0;
    logic          bus_wide = 1'b0;
    logic          rd_inc_en = 1'b0;
    logic          wr_inc_en = 1'b0;
    logic          access_done = 1'b0;
    logic          wrap_ie_we = 1'b0;
    logic          wrap_ie_d = 1'b0;
    logic          load_we = 1'b0;
    logic [AW-1:0] load_data = '0;
    logic          irq_ack = 1'b0;
    logic [AW-1:0] addr;
    logic          wrap_ie;
    logic          wrap_irq;

    int            n_checks = 0;
    int            n_fail = 0;
    int            cyc = 0;
    exp_t          sb[$];
    logic [AW-1:0] m_addr = '0;
    logic          m_ie = 1'b0;
    logic          m_irq = 1'b0;

    addr_wrap_incr #(.ADDR_W(AW)) u_addr_wrap_incr (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .mode_sel(mode_sel),
        .word_len(word_len), .bus_wide(bus_wide), .rd_inc_en(rd_inc_en),
        .wr_inc_en(wr_inc_en), .access_done(access_done), .wrap_ie_we(wrap_ie_we),
        .wrap_ie_d(wrap_ie_d), .load_we(load_we), .load_data(load_data),
        .irq_ack(irq_ack), .addr(addr), .wrap_ie(wrap_ie), .wrap_irq(wrap_irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Field width as the requirements R4, R5 and R6 define it.
    function automatic int field_w();
        if (mode_sel == 4'b1101) return 18;
        if (mode_sel == 4'b0101 && word_len == 3'b001 && bus_wide == 1'b0) return 16;
        return AW;
    endfunction

    // Driver: predict the result of this cycle, queue it, advance one cycle.
    task automatic tick(input string tag);
        exp_t e;
        logic [AW-1:0] msk;
        logic inc, wrap;
        msk = '0;
        for (int i = 0; i < field_w(); i++) msk[i] = 1'b1;
        inc  = access_done && (rd_inc_en || wr_inc_en);
        wrap = inc && !load_we && ((m_addr & msk) == msk);
        if (sw_rst) m_irq = 1'b0;
        else if (wrap && m_ie) m_irq = 1'b1;
        else if (irq_ack) m_irq = 1'b0;
        if (sw_rst) m_ie = 1'b0;
        else if (wrap_ie_we) m_ie = wrap_ie_d;
        if (load_we) m_addr = load_data;
        else if (inc) m_addr = (m_addr & ~msk) | ((m_addr + AW'(1)) & msk);
        e.due = cyc + 1; e.addr = m_addr; e.ie = m_ie; e.irq = m_irq; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        access_done = 1'b0; load_we = 1'b0; irq_ack = 1'b0;
        wrap_ie_we = 1'b0; sw_rst = 1'b0;
    endtask

    // Monitor: compare every prediction that has come due.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (addr !== e.addr || wrap_ie !== e.ie || wrap_irq !== e.irq) begin
                n_fail++;
                $display("FAIL %s: addr=%h ie=%b irq=%b expected addr=%h ie=%b irq=%b",
                         e.tag, addr, wrap_ie, wrap_irq, e.addr, e.ie, e.irq);
            end
        end
    end

    task automatic do_inc(input logic rd, input logic wr, input string tag);
        rd_inc_en = rd; wr_inc_en = wr; access_done = 1'b1; tick(tag);
    endtask

    task automatic do_load(input logic [AW-1:0] v, input string tag);
        load_we = 1'b1; load_data = v; tick(tag);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung, expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        n_checks++;
        if (addr !== '0 || wrap_ie !== 1'b0 || wrap_irq !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: addr=%h ie=%b irq=%b expected 000000 0 0", addr, wrap_ie, wrap_irq);
        end
        rst_n = 1'b1;
        wrap_ie_we = 1'b1; wrap_ie_d = 1'b1; tick("R12 enable write");
        do_load(24'h000010, "R10 load");
        do_inc(1'b1, 1'b0, "R2 read increment");
        do_inc(1'b0, 1'b1, "R2 write increment");
        do_inc(1'b0, 1'b0, "R3 no enables");
        do_load(24'hFFFFFF, "R10 load top");
        do_inc(1'b0, 1'b0, "R3 no wrap without enables");
        // R4 and R7: 18-bit field keeps bits 23:18.
        mode_sel = 4'b1101;
        do_load(24'hA3FFFE, "R10 load");
        do_inc(1'b1, 1'b0, "R4 step");
        do_inc(1'b1, 1'b0, "R4 R7 wrap of 18 bits");
        do_inc(1'b1, 1'b0, "R8 sticky");
        irq_ack = 1'b1; tick("R9 ack clears");
        // R5: 16-bit field.
        mode_sel = 4'b0101; word_len = 3'b001; bus_wide = 1'b0;
        do_load(24'h12FFFF, "R10 load");
        do_inc(1'b0, 1'b1, "R5 wrap of 16 bits");
        do_load(24'h34FFFF, "R10 load");
        irq_ack = 1'b1; do_inc(1'b1, 1'b0, "R9 set beats ack");
        irq_ack = 1'b1; tick("R9 ack");
        // R6: other combinations use the full width.
        bus_wide = 1'b1;
        do_load(24'h12FFFF, "R10 load");
        do_inc(1'b1, 1'b0, "R6 no wrap at 16 bits, bus wide");
        bus_wide = 1'b0; word_len = 3'b000;
        do_load(24'h03FFFF, "R10 load");
        do_inc(1'b1, 1'b0, "R6 no wrap at 18 bits");
        do_load(24'hFFFFFF, "R10 load");
        do_inc(1'b1, 1'b0, "R6 full width wrap");
        irq_ack = 1'b1; tick("R9 ack");
        // R8: no request while disabled.
        wrap_ie_we = 1'b1; wrap_ie_d = 1'b0; tick("R12 disable");
        do_load(24'hFFFFFF, "R10 load");
        do_inc(1'b1, 1'b1, "R8 disabled wrap");
        // R10: load beats a wrapping increment.
        wrap_ie_we = 1'b1; wrap_ie_d = 1'b1; tick("R12 enable");
        do_load(24'hFFFFFF, "R10 load");
        load_we = 1'b1; load_data = 24'h5A5A5A; do_inc(1'b1, 1'b0, "R10 load over wrap");
        // R11: software reset.
        do_load(24'hFFFFFF, "R10 load");
        do_inc(1'b1, 1'b0, "R8 wrap");
        sw_rst = 1'b1; tick("R11 soft reset");
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule